// File: doc/BRIEF.md
# GPIO Controller with Interrupts

The block is a 32-pin general-purpose I/O controller. Software reaches it over a simple word-addressed register bus. Each pin is either an input or an output, as set by a direction register. The driven value sits in an output-data register. That register changes only through two strobe addresses: one that sets every bit written as 1, and one that clears every bit written as 1. Input levels pass through a two-flop synchroniser and can be read back.

Every pin also carries interrupt logic, programmed by three independent per-pin controls:
- **Mode** selects level or edge sensitivity.
- **Any-edge** makes an edge-mode pin fire on either transition.
- **Invert** selects the falling edge or the active-low level.

Detected events are held in pending bits. The pending bits can be read both raw and ANDed with the enable mask, and the OR of the masked bits drives a single active-high interrupt line. Writing 1s to the acknowledge address clears pending bits. A level source whose condition is still active comes back one cycle after the acknowledge.

Top module: `gpio_irq_ctrl`

## Requirements
- R1: After reset every register reads 0, `pin_oe` and `pin_out` are 0 and `irq` is 0.
- R2: Writing word 2 sets the direction mask. A bit of 1 drives that pin (`pin_oe` bit high). The value reads back at word 2.
- R3: Writing word 3 sets the output bits written as 1, and writing word 4 clears the output bits written as 1. Bits written as 0 are unchanged. The output value reads back at word 0 and drives `pin_out`.
- R4: Word 1 returns the pin levels after a two-flop synchroniser. A pin change is visible after the second clock edge.
- R5: With mode bit 0 (edge, word 9), any-edge bit 0 (word 10) and invert bit 0 (word 11), a rising input sets the raw pending bit (word 6) on the third clock edge after the change. A falling input does not set it.
- R6: In edge mode with invert bit 1, only a falling input sets the pending bit.
- R7: In edge mode with any-edge bit 1, both transitions set the pending bit, whatever the invert bit holds.
- R8: With mode bit 1 (level), the pending bit is set while the synchronised pin equals NOT invert, and it stays set after the level goes away. An acknowledge of an active level pin clears the bit for one cycle, and the bit returns on the next edge.
- R9: Word 7 reads raw pending AND enable (word 5). `irq` is 1 exactly when any masked bit is set.
- R10: Edge events set the pending bit while the pin's enable is 0. Enabling the pin later raises the masked bit and `irq`. A pending bit never clears without an acknowledge.
- R11: Writing word 8 clears the pending bits written as 1. An edge event that falls in the same cycle as its acknowledge stays pending.
- R12: Reads of write-only words (3, 4, 8) and of unmapped words return 0. Writes to unmapped words change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_we | input | 1 | Write strobe for the addressed word |
| bus_addr | input | 4 | Word address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr`, combinational |
| pin_in | input | 32 | Pin input levels (asynchronous) |
| pin_out | output | 32 | Output data to the pads |
| pin_oe | output | 32 | Output enable per pin |
| irq | output | 1 | Aggregated interrupt, active high |

## Verification
The bound checker watches, on every cycle:
- that set and clear strobes touch only the bits written as 1;
- that a direction write lands on `pin_oe`;
- that a pending bit never drops without an acknowledge;
- that an acknowledged level bit is clear in the following cycle;
- that `irq` never rises with an empty enable mask;
- the quiet state after reset.

Some behaviours only the bench scenarios can show:
- the synchroniser latency;
- the choice of edge by the invert and any-edge controls;
- the level source returning after an acknowledge while still active;
- an edge surviving an acknowledge in the same cycle.

// File: rtl/gpio_irq_ctrl.sv
module gpio_irq_ctrl #(
  parameter int PINS = 32,
  parameter int AW   = 4
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            bus_we,
  input  logic [AW-1:0]   bus_addr,
  input  logic [PINS-1:0] bus_wdata,
  output logic [PINS-1:0] bus_rdata,
  input  logic [PINS-1:0] pin_in,
  output logic [PINS-1:0] pin_out,
  output logic [PINS-1:0] pin_oe,
  output logic            irq
);
  localparam logic [AW-1:0] A_DOUT = AW'(0);
  localparam logic [AW-1:0] A_DIN  = AW'(1);
  localparam logic [AW-1:0] A_DIR  = AW'(2);
  localparam logic [AW-1:0] A_SET  = AW'(3);
  localparam logic [AW-1:0] A_CLR  = AW'(4);
  localparam logic [AW-1:0] A_IEN  = AW'(5);
  localparam logic [AW-1:0] A_RAW  = AW'(6);
  localparam logic [AW-1:0] A_MSK  = AW'(7);
  localparam logic [AW-1:0] A_ACK  = AW'(8);
  localparam logic [AW-1:0] A_MODE = AW'(9);
  localparam logic [AW-1:0] A_ANY  = AW'(10);
  localparam logic [AW-1:0] A_INV  = AW'(11);

  logic [PINS-1:0] dout, dir, ien, mode, any, inv, pend;
  logic [PINS-1:0] sync1, sync2, prev;
  logic [PINS-1:0] ack, rise, fall, edge_hit, lvl_hit;

  assign ack  = (bus_we && bus_addr == A_ACK) ? bus_wdata : '0;
  assign rise = sync2 & ~prev;
  assign fall = ~sync2 & prev;

  assign edge_hit = ~mode & ((any & (rise | fall)) |
                             (~any & inv & fall) |
                             (~any & ~inv & rise));
  assign lvl_hit  = mode & (sync2 ^ inv);

  assign pin_out = dout;
  assign pin_oe  = dir;
  assign irq     = |(pend & ien);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync1 <= '0;
      sync2 <= '0;
      prev  <= '0;
    end else begin
      sync1 <= pin_in;
      sync2 <= sync1;
      prev  <= sync2;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dout <= '0;
      dir  <= '0;
      ien  <= '0;
      mode <= '0;
      any  <= '0;
      inv  <= '0;
    end else if (bus_we) begin
      case (bus_addr)
        A_SET:   dout <= dout | bus_wdata;
        A_CLR:   dout <= dout & ~bus_wdata;
        A_DIR:   dir  <= bus_wdata;
        A_IEN:   ien  <= bus_wdata;
        A_MODE:  mode <= bus_wdata;
        A_ANY:   any  <= bus_wdata;
        A_INV:   inv  <= bus_wdata;
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pend <= '0;
    else        pend <= (pend & ~ack) | edge_hit | (lvl_hit & ~ack);
  end

  always_comb begin
    case (bus_addr)
      A_DOUT:  bus_rdata = dout;
      A_DIN:   bus_rdata = sync2;
      A_DIR:   bus_rdata = dir;
      A_IEN:   bus_rdata = ien;
      A_RAW:   bus_rdata = pend;
      A_MSK:   bus_rdata = pend & ien;
      A_MODE:  bus_rdata = mode;
      A_ANY:   bus_rdata = any;
      A_INV:   bus_rdata = inv;
      default: bus_rdata = '0;
    endcase
  end
endmodule

// File: rtl/gpio_irq_ctrl_chk.sv
module gpio_irq_ctrl_chk #(
  parameter int PINS = 32,
  parameter int AW   = 4
) (
  input logic            clk,
  input logic            rst_n,
  input logic            bus_we,
  input logic [AW-1:0]   bus_addr,
  input logic [PINS-1:0] bus_wdata,
  input logic [PINS-1:0] pin_out,
  input logic [PINS-1:0] pin_oe,
  input logic            irq,
  input logic [PINS-1:0] pend,
  input logic [PINS-1:0] ien,
  input logic [PINS-1:0] mode
);
  logic wr_set, wr_clr, wr_dir, wr_ack;
  assign wr_set = bus_we && bus_addr == AW'(3);
  assign wr_clr = bus_we && bus_addr == AW'(4);
  assign wr_dir = bus_we && bus_addr == AW'(2);
  assign wr_ack = bus_we && bus_addr == AW'(8);

  p_reset_quiet_r1: assert property (@(posedge clk)
    !rst_n |=> (pin_oe == '0 && pin_out == '0 && !irq));

  p_dir_write_r2: assert property (@(posedge clk) disable iff (!rst_n)
    wr_dir |=> pin_oe == $past(bus_wdata));

  p_set_bits_r3: assert property (@(posedge clk) disable iff (!rst_n)
    wr_set |=> ((pin_out & $past(bus_wdata)) == $past(bus_wdata)) &&
               ((pin_out & ~$past(bus_wdata)) == ($past(pin_out) & ~$past(bus_wdata))));

  p_clr_bits_r3: assert property (@(posedge clk) disable iff (!rst_n)
    wr_clr |=> ((pin_out & $past(bus_wdata)) == '0) &&
               ((pin_out & ~$past(bus_wdata)) == ($past(pin_out) & ~$past(bus_wdata))));

  p_level_ack_gap_r8: assert property (@(posedge clk) disable iff (!rst_n)
    wr_ack |=> (pend & $past(bus_wdata) & $past(mode)) == '0);

  p_irq_needs_enable_r9: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> ien != '0);

  p_pend_sticky_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_ack |=> ($past(pend) & ~pend) == '0);
endmodule

bind gpio_irq_ctrl gpio_irq_ctrl_chk #(.PINS(PINS), .AW(AW)) u_chk (
  .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_addr(bus_addr),
  .bus_wdata(bus_wdata), .pin_out(pin_out), .pin_oe(pin_oe), .irq(irq),
  .pend(pend), .ien(ien), .mode(mode)
);

// File: tb/gpio_irq_ctrl_test.sv
`timescale 1ns/1ps
module gpio_irq_ctrl_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_we = 1'b0;
  logic [3:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic [31:0] pin_in = '0;
  logic [31:0] pin_out, pin_oe;
  logic        irq;
  int          errors = 0;
  int          checks = 0;
  bit          done = 1'b0;

  always #2 clk = ~clk;

  gpio_irq_ctrl uut (
    .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pin_in(pin_in),
    .pin_out(pin_out), .pin_oe(pin_oe), .irq(irq)
  );

  localparam logic [1:0] K_W = 2'd0, K_R = 2'd1, K_P = 2'd2, K_I = 2'd3;
  localparam int NV = 68;
  // {req, kind, word, data, expected}
  localparam logic [73:0] VEC [NV] = '{
    {4'd1,  K_R, 4'd0,  32'h0,        32'h0},        // R1
    {4'd1,  K_R, 4'd2,  32'h0,        32'h0},        // R1
    {4'd1,  K_R, 4'd6,  32'h0,        32'h0},        // R1
    {4'd1,  K_I, 4'd0,  32'h0,        32'h0},        // R1
    {4'd2,  K_W, 4'd2,  32'h0000FFFF, 32'h0},
    {4'd2,  K_R, 4'd2,  32'h0,        32'h0000FFFF}, // R2
    {4'd3,  K_W, 4'd3,  32'hF0,       32'h0},
    {4'd3,  K_R, 4'd0,  32'h0,        32'hF0},       // R3
    {4'd3,  K_W, 4'd4,  32'h30,       32'h0},
    {4'd3,  K_R, 4'd0,  32'h0,        32'hC0},       // R3
    {4'd3,  K_W, 4'd3,  32'h0,        32'h0},
    {4'd3,  K_R, 4'd0,  32'h0,        32'hC0},       // R3
    {4'd4,  K_P, 4'd0,  32'hA5A50000, 32'h0},
    {4'd4,  K_R, 4'd1,  32'h0,        32'hA5A50000}, // R4
    {4'd5,  K_R, 4'd6,  32'h0,        32'hA5A50000}, // R5
    {4'd9,  K_R, 4'd7,  32'h0,        32'h0},        // R9
    {4'd11, K_W, 4'd8,  32'hFFFFFFFF, 32'h0},
    {4'd11, K_R, 4'd6,  32'h0,        32'h0},        // R11
    {4'd5,  K_P, 4'd0,  32'h0,        32'h0},
    {4'd5,  K_R, 4'd6,  32'h0,        32'h0},        // R5
    {4'd6,  K_W, 4'd11, 32'h1,        32'h0},
    {4'd6,  K_P, 4'd0,  32'h1,        32'h0},
    {4'd6,  K_R, 4'd6,  32'h0,        32'h0},        // R6
    {4'd6,  K_P, 4'd0,  32'h0,        32'h0},
    {4'd6,  K_R, 4'd6,  32'h0,        32'h1},        // R6
    {4'd6,  K_W, 4'd8,  32'h1,        32'h0},
    {4'd7,  K_W, 4'd10, 32'h2,        32'h0},
    {4'd7,  K_W, 4'd11, 32'h3,        32'h0},
    {4'd7,  K_P, 4'd0,  32'h2,        32'h0},
    {4'd7,  K_R, 4'd6,  32'h0,        32'h2},        // R7
    {4'd7,  K_W, 4'd8,  32'h2,        32'h0},
    {4'd7,  K_P, 4'd0,  32'h0,        32'h0},
    {4'd7,  K_R, 4'd6,  32'h0,        32'h2},        // R7
    {4'd7,  K_W, 4'd8,  32'h2,        32'h0},
    {4'd9,  K_W, 4'd5,  32'h2,        32'h0},
    {4'd9,  K_P, 4'd0,  32'h2,        32'h0},
    {4'd9,  K_R, 4'd7,  32'h0,        32'h2},        // R9
    {4'd9,  K_I, 4'd0,  32'h0,        32'h1},        // R9
    {4'd9,  K_W, 4'd8,  32'h2,        32'h0},
    {4'd10, K_W, 4'd5,  32'h0,        32'h0},
    {4'd10, K_P, 4'd0,  32'h0,        32'h0},
    {4'd10, K_R, 4'd7,  32'h0,        32'h0},        // R10
    {4'd10, K_I, 4'd0,  32'h0,        32'h0},        // R10
    {4'd10, K_W, 4'd5,  32'h2,        32'h0},
    {4'd10, K_R, 4'd7,  32'h0,        32'h2},        // R10
    {4'd10, K_W, 4'd8,  32'h2,        32'h0},
    {4'd10, K_W, 4'd5,  32'h0,        32'h0},
    {4'd8,  K_W, 4'd9,  32'h4,        32'h0},
    {4'd8,  K_P, 4'd0,  32'h4,        32'h0},
    {4'd8,  K_R, 4'd6,  32'h0,        32'h4},        // R8
    {4'd8,  K_W, 4'd8,  32'h4,        32'h0},
    {4'd8,  K_R, 4'd6,  32'h0,        32'h0},        // R8
    {4'd8,  K_R, 4'd6,  32'h0,        32'h4},        // R8
    {4'd8,  K_P, 4'd0,  32'h0,        32'h0},
    {4'd8,  K_R, 4'd6,  32'h0,        32'h4},        // R8
    {4'd8,  K_W, 4'd8,  32'h4,        32'h0},
    {4'd8,  K_R, 4'd6,  32'h0,        32'h0},        // R8
    {4'd8,  K_R, 4'd6,  32'h0,        32'h0},        // R8
    {4'd8,  K_W, 4'd11, 32'h7,        32'h0},
    {4'd8,  K_P, 4'd0,  32'h0,        32'h0},
    {4'd8,  K_R, 4'd6,  32'h0,        32'h4},        // R8
    {4'd11, K_W, 4'd9,  32'h0,        32'h0},
    {4'd11, K_W, 4'd8,  32'hFFFFFFFF, 32'h0},
    {4'd11, K_R, 4'd6,  32'h0,        32'h0},        // R11
    {4'd12, K_R, 4'd12, 32'h0,        32'h0},        // R12
    {4'd12, K_R, 4'd3,  32'h0,        32'h0},        // R12
    {4'd12, K_W, 4'd13, 32'hFFFFFFFF, 32'h0},
    {4'd12, K_R, 4'd2,  32'h0,        32'h0000FFFF}  // R12
  };

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic bus_write(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_we = 1'b1;
    @(posedge clk);
    #1 bus_we = 1'b0;
  endtask

  task automatic bus_read(input logic [3:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_addr = a;
    #1 d = bus_rdata;
  endtask

  task automatic drive_pins(input logic [31:0] d);
    @(negedge clk);
    pin_in = d;
    repeat (4) @(posedge clk);
  endtask

  task automatic report;
    if (!done) begin
      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    report();
  end

  initial begin
    logic [31:0] rd;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    @(negedge clk);
    check("R1 pin_oe after reset", pin_oe, 32'h0);
    check("R1 pin_out after reset", pin_out, 32'h0);

    for (int i = 0; i < NV; i++) begin
      logic [3:0]  req;
      logic [1:0]  kind;
      logic [3:0]  wa;
      logic [31:0] dat, exp;
      {req, kind, wa, dat, exp} = VEC[i];
      case (kind)
        K_W: bus_write(wa, dat);
        K_P: drive_pins(dat);
        K_R: begin
          bus_read(wa, rd);
          check($sformatf("R%0d vec %0d word %0d", req, i, wa), rd, exp);
        end
        default: begin
          @(negedge clk);
          check($sformatf("R%0d vec %0d irq", req, i), {31'b0, irq}, exp);
        end
      endcase
    end

    @(negedge clk);
    check("R2 pin_oe follows direction", pin_oe, 32'h0000FFFF);
    check("R3 pin_out follows output data", pin_out, 32'h000000C0);

    // R11: rising edge on pin 3 detected in the same cycle as its acknowledge
    @(negedge clk);
    pin_in = 32'h8;
    @(posedge clk);
    @(posedge clk);
    #1 bus_addr = 4'd8; bus_wdata = 32'hFFFFFFFF; bus_we = 1'b1;
    @(posedge clk);
    #1 bus_we = 1'b0;
    bus_read(4'd6, rd);
    check("R11 edge kept across same-cycle ack", rd, 32'h8);
    bus_write(4'd8, 32'h8);
    bus_read(4'd6, rd);
    check("R11 ack clears pending", rd, 32'h0);

    // R1: reset in mid-run returns every register to zero
    bus_write(4'd5, 32'hFFFFFFFF);
    bus_write(4'd9, 32'hF);
    @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    check("R1 pin_oe after second reset", pin_oe, 32'h0);
    check("R1 pin_out after second reset", pin_out, 32'h0);
    check("R1 irq after second reset", {31'b0, irq}, 32'h0);
    bus_read(4'd5, rd);
    check("R1 enable after second reset", rd, 32'h0);
    bus_read(4'd9, rd);
    check("R1 mode after second reset", rd, 32'h0);

    report();
  end
endmodule